// File: doc/BRIEF.md
# Streaming Segmented Prefix Scan

This block computes a running sum over a stream of 32-bit integer elements, one element per clock. The stream is split into segments. Each element carries a segment-start flag. When the flag is set, the sum restarts from that element, so every segment is scanned on its own. A stream ends with an end marker. After the marker the running sum clears, and the next element opens a fresh stream.

For each element, a mode input chooses one of two results. Inclusive mode gives the segment sum up to and including the element. Exclusive mode gives the sum of the earlier elements only, so a segment's first element yields 0. The mode is sampled together with each element. Results leave through a single output register. The input is stalled through its ready signal while a result waits on the output side, so no element is lost and none is repeated.

Top module: `seg_scan_stream`

## Requirements
- R1: With `excl_mode` low at acceptance, an element's result is the wraparound sum of all elements of its segment, from the segment's first element up to and including itself.
- R2: With `excl_mode` high at acceptance, an element's result is the sum of the earlier elements of its segment, and a segment's first element gives 0.
- R3: An accepted element with `in_seg_start` = 1 begins a new segment whose sum starts from that element; for example, data 3,1,7,0,4,1,6,3 with flags 1,0,0,1,0,0,1,0 gives inclusive results 3,4,11,0,4,5,6,9.
- R4: The first element after reset, and the first element after an element accepted with `in_end` = 1, begins a new segment even when its start flag is 0.
- R5: Sums are 32 bits wide and wrap modulo 2^32 (0xFFFFFFFF + 2 gives 1).
- R6: An element accepted at a clock edge (`in_valid` and `in_ready` both high) has its result presented with `out_valid` = 1 right after that same edge.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_data` and `out_end` stay unchanged into the next cycle.
- R8: `out_end` is 1 exactly on the result of an element accepted with `in_end` = 1.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1. Every accepted element produces exactly one result, and results keep the order of their elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| excl_mode | input | 1 | 1 selects the exclusive result and 0 the inclusive result, sampled with each element |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Unit can take an element this cycle |
| in_data | input | 32 | Element value |
| in_seg_start | input | 1 | Element opens a new segment |
| in_end | input | 1 | Element is the last of its stream |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Scan result |
| out_end | output | 1 | Result belongs to the stream's last element |

## Verification
The assertions assume that `excl_mode`, `in_data`, `in_seg_start` and `in_end` are steady whenever `in_valid` is high. They also assume that `out_ready` is only sampled at clock edges, and that reset is applied before the first handshake. The bench drives every input only just after a rising edge and holds it until the handshake completes. It applies bursts with random idle gaps and a random `out_ready` pattern, so the stall paths are exercised while these assumptions hold.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  parameter int unsigned SCAN_W = 32;

  typedef logic [SCAN_W-1:0] sum_t;

  // Value the running sum restarts from
  localparam sum_t SUM_IDENT = '0;

  // Base value for the element: identity on a segment opening, else the carried sum
  function automatic sum_t scan_base(input logic opens, input sum_t carried);
    return opens ? SUM_IDENT : carried;
  endfunction

  // Modular addition, carry out is discarded
  function automatic sum_t wrap_add(input sum_t a, input sum_t b);
    return a + b;
  endfunction

  // Result selection by mode
  function automatic sum_t pick_result(input logic excl, input sum_t base, input sum_t incl);
    return excl ? base : incl;
  endfunction

endpackage

// File: rtl/seg_scan_accum.sv
module seg_scan_accum
  import seg_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic excl_mode,
  input  sum_t data,
  input  logic seg_start,
  input  logic is_end,
  output sum_t result,
  output logic stream_fresh
);

  sum_t carry_q;
  logic fresh_q;
  logic opens;
  sum_t base_v;
  sum_t incl_v;

  assign opens        = seg_start | fresh_q;
  assign base_v       = scan_base(opens, carry_q);
  assign incl_v       = wrap_add(base_v, data);
  assign result       = pick_result(excl_mode, base_v, incl_v);
  assign stream_fresh = fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= SUM_IDENT;
      fresh_q <= 1'b1;
    end else if (fire) begin
      carry_q <= is_end ? SUM_IDENT : incl_v;
      fresh_q <= is_end;
    end
  end

  AST_FRESH_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_end |=> stream_fresh); // R4

  AST_FRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !is_end |=> !stream_fresh); // R4

endmodule

// File: rtl/seg_scan_outreg.sv
module seg_scan_outreg
  import seg_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  sum_t load_data,
  input  logic load_end,
  input  logic out_ready,
  output logic out_valid,
  output sum_t out_data,
  output logic out_end,
  output logic can_take
);

  logic valid_q;
  sum_t data_q;
  logic end_q;
  logic stalled;

  assign stalled   = valid_q & ~out_ready;
  assign can_take  = ~stalled;
  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_end   = end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= SUM_IDENT;
      end_q   <= 1'b0;
    end else if (!stalled) begin
      valid_q <= load;
      if (load) begin
        data_q <= load_data;
        end_q  <= load_end;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_end)); // R7

endmodule

// File: rtl/seg_scan_stream.sv
module seg_scan_stream
  import seg_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              excl_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SCAN_W-1:0] in_data,
  input  logic              in_seg_start,
  input  logic              in_end,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SCAN_W-1:0] out_data,
  output logic              out_end
);

  logic fire;
  logic take_ok;
  sum_t scan_res;
  logic stream_fresh;

  assign in_ready = take_ok;
  assign fire     = in_valid & take_ok;

  seg_scan_accum u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .excl_mode    (excl_mode),
    .data         (in_data),
    .seg_start    (in_seg_start),
    .is_end       (in_end),
    .result       (scan_res),
    .stream_fresh (stream_fresh)
  );

  seg_scan_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .load_data (scan_res),
    .load_end  (in_end),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_end   (out_end),
    .can_take  (take_ok)
  );

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_EXCL_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_seg_start && excl_mode |=> out_data == '0); // R2

  AST_INCL_HEAD_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_seg_start && !excl_mode |=> out_data == $past(in_data)); // R3

  AST_FRESH_HEAD_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    fire && stream_fresh && !excl_mode |=> out_data == $past(in_data)); // R4

  AST_END_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_end == $past(in_end)); // R8

endmodule

// File: tb/test_seg_scan_stream.sv
`timescale 1ns/1ps
module test_seg_scan_stream;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        excl_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_seg_start = 1'b0;
  logic        in_end = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_end;

  typedef struct packed {
    logic [31:0] val;
    logic        fin;
    logic        excl;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   n_out    = 0;
  int   n_in     = 0;
  bit   bp_on    = 1'b0;
  bit   monitor_on = 1'b0;
  bit   done     = 1'b0;

  // reference model state
  logic [31:0] m_sum = '0;
  bit          m_fresh = 1'b1;

  always #2 clk = ~clk;

  seg_scan_stream i_seg_scan_stream (
    .clk(clk), .rst_n(rst_n), .excl_mode(excl_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_seg_start(in_seg_start), .in_end(in_end),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_end(out_end)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: present one element, wait for handshake, record expectation
  task automatic send(input logic [31:0] d, input bit head, input bit fin, input bit ex, input int gap);
    logic [31:0] base;
    logic [31:0] incl;
    exp_t e;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
    end
    in_valid = 1'b1; in_data = d; in_seg_start = head; in_end = fin; excl_mode = ex;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    // R3/R4: segment opens on flag or on fresh stream; R5: 32-bit wrap
    base = (head || m_fresh) ? 32'd0 : m_sum;
    incl = base + d;
    e.val = ex ? base : incl;
    e.fin = fin;
    e.excl = ex;
    exp_q.push_back(e);
    n_in++;
    m_sum   = fin ? 32'd0 : incl;
    m_fresh = fin;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Consumer side ready pattern
  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor / scoreboard
  bit          acc_prev = 1'b0;
  bit          stall_prev = 1'b0;
  logic [31:0] stall_data;
  logic        stall_end;
  always @(negedge clk) begin
    if (monitor_on) begin
      if (acc_prev)
        check(out_valid === 1'b1, "R6 result valid one cycle after accept", {31'd0, out_valid}, 32'd1);
      if (stall_prev) begin
        check(out_valid === 1'b1 && out_data === stall_data && out_end === stall_end,
              "R7 stalled output held", out_data, stall_data);
      end
      if (out_valid && !out_ready)
        check(in_ready === 1'b0, "R7 input blocked during stall", {31'd0, in_ready}, 32'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected extra result", out_data, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          n_out++;
          check(out_data === e.val, e.excl ? "R2 exclusive result" : "R1 inclusive result", out_data, e.val);
          check(out_end === e.fin, "R8 end marker", {31'd0, out_end}, {31'd0, e.fin});
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      stall_end  = out_end;
      acc_prev   = in_valid && in_ready;
    end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d results", n_out, n_in);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic drain();
    int w;
    w = 0;
    while ((exp_q.size() != 0 || out_valid) && w < 200) begin
      @(posedge clk); #1;
      w++;
    end
  endtask

  initial begin
    logic [31:0] ex_d [8];
    bit          ex_h [8];
    ex_d = '{32'd3, 32'd1, 32'd7, 32'd0, 32'd4, 32'd1, 32'd6, 32'd3};
    ex_h = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0, "R9 out_valid low after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready === 1'b1, "R9 in_ready high after reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    monitor_on = 1'b1;

    // R1/R3: worked example, inclusive
    for (int i = 0; i < 8; i++) send(ex_d[i], ex_h[i], i == 7, 1'b0, 0);
    drain();
    // R2: same data, exclusive (expect 0,3,4,0,0,4,0,6)
    for (int i = 0; i < 8; i++) send(ex_d[i], ex_h[i], i == 7, 1'b1, 0);
    drain();
    // R4: stream opening without a start flag, then after an end marker
    send(32'd10, 1'b0, 1'b0, 1'b0, 0);
    send(32'd5,  1'b0, 1'b1, 1'b0, 0);
    send(32'd9,  1'b0, 1'b0, 1'b0, 0);
    send(32'd2,  1'b0, 1'b1, 1'b1, 0);
    drain();
    // R5: wraparound
    send(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 0);
    send(32'd2,         1'b0, 1'b0, 1'b0, 0);
    send(32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 0);
    drain();
    // R1/R2: mode switching per element
    for (int i = 0; i < 12; i++) send(32'd100 + i, i % 5 == 0, i == 11, i[0], 0);
    drain();
    // R7/R9: random traffic with back-pressure and idle gaps
    bp_on = 1'b1;
    for (int i = 0; i < 600; i++)
      send($urandom, ($urandom % 6) == 0, ($urandom % 40) == 0 || i == 599,
           ($urandom % 2) == 1, $urandom % 3);
    bp_on = 1'b0;
    drain();
    // R9: no element lost or duplicated
    check(exp_q.size() == 0 && n_out == n_in, "R9 one result per element", n_out, n_in);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule